// File: doc/BRIEF.md
# Alternate Address Space Request Router

This block sits behind the load-alternate and store-alternate datapath of a processor core. Each request carries an 8-bit space identifier, an address, a byte count (1, 2, 4 or 8), a direction and up to 64 bits of write data. The router classifies the identifier and sends the request to one of several destinations. Some requests go out as word-wide beats on a memory port, either to instruction space or to physical space. Some are absorbed with no effect, and some finish at once with a fault strobe to the fault capture logic.

Two identifiers on the store side start multi-beat sequences. One copies a 32-byte block from a source address carried in the write data to the request address. The other fills a 32-byte block with a repeated 64-bit pattern. Only one request is in flight at a time. The input handshake stays closed from acceptance until the response strobe, and every memory beat waits for the memory to complete it.

Top module: `altspace_router`

## Requirements
- R1: A read with identifier 0x09 is an instruction-space fetch (mem_code=1). A byte count of 1 keeps the address, 2 clears address bit 0, and 4 or any unlisted count clears bits 1:0 and is treated as a word. mem_size is 0 for a byte, 1 for a halfword and 2 for a word. The response holds the low 1, 2 or 4 bytes of mem_rdata, zero-extended.
- R2: An 8-byte read with identifier 0x09 or 0x20 issues two word reads, at A (the address with bits 1:0 cleared) and then at A+4. The response is {first word, second word}.
- R3: Identifier 0x20 reaches physical space (mem_code=0) for reads and writes. An 8-byte write stores req_wdata[63:32] at A and then req_wdata[31:0] at A+4. Smaller writes issue one beat carrying req_wdata[31:0].
- R4: Any identifier not named in R1 to R3 or R5 to R9 for that direction is unassigned. This includes 0x21 to 0x2F in both directions. Such a request issues no memory beat. One cycle after acceptance it raises fault_valid together with resp_valid, with resp_rdata=0, fault_alt=1, fault_addr equal to the request address and fault_write equal to the request direction.
- R5: Identifiers 0x0C to 0x0F complete with no memory beat and no fault in both directions, and a read returns zero.
- R6: Writes to 0x02, 0x10 to 0x14, 0x31, 0x36 and 0x37 and reads of 0x02 complete with no memory beat and no fault. A read of 0x02 returns zero.
- R7: A write with identifier 0x09 is unassigned and faults with fault_write=1. The instruction-space path never carries a write.
- R8: A write with identifier 0x17 copies 8 words. For i = 0 to 7 it reads from S+4i, where S is req_wdata[31:0] with bits 1:0 cleared, and then writes that word to D+4i, where D is the request address with bits 1:0 cleared.
- R9: A write with identifier 0x1F issues 8 word writes at F+4i, where F is the request address with bits 2:0 cleared. Even i carries req_wdata[63:32] and odd i carries req_wdata[31:0].
- R10: req_ready is high only when the router is idle. While mem_valid is high and mem_ready low, the beat's address, direction and data hold. resp_valid is a one-cycle pulse: the cycle after acceptance for a request with no memory beats, otherwise the cycle after the last beat completes.
- R11: After reset, req_ready is 1 and mem_valid, resp_valid and fault_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_asi | input | 8 | Space identifier |
| req_addr | input | 32 | Request address |
| req_size | input | 4 | Byte count: 1, 2, 4 or 8 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data |
| mem_valid | output | 1 | Memory beat present |
| mem_ready | input | 1 | Memory completes the beat |
| mem_addr | output | 32 | Aligned beat address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_write | output | 1 | Beat direction |
| mem_wdata | output | 32 | Beat store data |
| mem_code | output | 1 | 1 = instruction space, 0 = physical |
| mem_rdata | input | 32 | Beat load data, right-justified |
| resp_valid | output | 1 | Request completion pulse |
| resp_rdata | output | 64 | Load result |
| fault_valid | output | 1 | Unassigned access strobe |
| fault_addr | output | 32 | Faulting request address |
| fault_write | output | 1 | Faulting request was a store |
| fault_alt | output | 1 | Fault came from an alternate-space access |

## Verification
The bound checker watches several rules on every cycle. Beats must hold while stalled, and the response must be a single pulse. A fault must come with a zero response exactly one cycle after acceptance, and a request that completes without beats must return zero. Halfword and word beats must be aligned, and the instruction path must never write. The routing table for every identifier can only be shown by the bench. It sweeps all 256 identifiers in both directions and counts beats and faults. The exact beat address sequences and data ordering for 8-byte, copy and fill requests also need the bench's directed scenarios, some of them run with a stalling memory.

// File: rtl/altspace_pkg.sv
package altspace_pkg;
  localparam int ASI_W  = 8;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int DWORD_W = 2 * WORD_W;

  localparam logic [ASI_W-1:0] SP_STUB      = 8'h02;
  localparam logic [ASI_W-1:0] SP_CODE      = 8'h09;
  localparam logic [ASI_W-1:0] SP_CACHE_LO  = 8'h0C;
  localparam logic [ASI_W-1:0] SP_CACHE_HI  = 8'h0F;
  localparam logic [ASI_W-1:0] SP_FLUSH_LO  = 8'h10;
  localparam logic [ASI_W-1:0] SP_FLUSH_HI  = 8'h14;
  localparam logic [ASI_W-1:0] SP_BCOPY     = 8'h17;
  localparam logic [ASI_W-1:0] SP_BFILL     = 8'h1F;
  localparam logic [ASI_W-1:0] SP_PHYS      = 8'h20;
  localparam logic [ASI_W-1:0] SP_IFLUSH    = 8'h31;
  localparam logic [ASI_W-1:0] SP_ICLEAR    = 8'h36;
  localparam logic [ASI_W-1:0] SP_DCLEAR    = 8'h37;

  typedef enum logic [2:0] {
    RT_NOP, RT_CODE, RT_PHYS, RT_COPY, RT_FILL, RT_FAULT
  } route_e;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_e;

  // log2 of the access width; unlisted byte counts fall back to a word
  function automatic logic [1:0] size_lg(input logic [3:0] nbytes);
    case (nbytes)
      4'd1:    return 2'd0;
      4'd2:    return 2'd1;
      4'd8:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] align_to(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] lg);
    case (lg)
      2'd0:    return a;
      2'd1:    return {a[ADDR_W-1:1], 1'b0};
      default: return {a[ADDR_W-1:2], 2'b00};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] zext_lg(input logic [WORD_W-1:0] d,
                                                input logic [1:0] lg);
    case (lg)
      2'd0:    return {{(WORD_W-8){1'b0}}, d[7:0]};
      2'd1:    return {{(WORD_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/altspace_decode.sv
module altspace_decode
  import altspace_pkg::*;
(
  input  logic [ASI_W-1:0] asi,
  input  logic             wr,
  output route_e           route
);
  logic in_cache, in_flush, is_clear;

  always_comb begin
    in_cache = (asi >= SP_CACHE_LO) && (asi <= SP_CACHE_HI);
    in_flush = (asi >= SP_FLUSH_LO) && (asi <= SP_FLUSH_HI);
    is_clear = (asi == SP_IFLUSH) || (asi == SP_ICLEAR) || (asi == SP_DCLEAR);
    route = RT_FAULT;
    if (asi == SP_PHYS) begin
      route = RT_PHYS;
    end else if (asi == SP_STUB || in_cache) begin
      route = RT_NOP;
    end else if (!wr) begin
      if (asi == SP_CODE) route = RT_CODE;
    end else begin
      if (in_flush || is_clear)  route = RT_NOP;
      else if (asi == SP_BCOPY)  route = RT_COPY;
      else if (asi == SP_BFILL)  route = RT_FILL;
    end
  end
endmodule

// File: rtl/altspace_beatgen.sv
module altspace_beatgen
  import altspace_pkg::*;
#(
  parameter int COPY_WORDS = 8,
  localparam int BEAT_W = $clog2(2 * COPY_WORDS)
) (
  input  route_e              route,
  input  logic [1:0]          lg,
  input  logic [BEAT_W-1:0]   beat,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   src,
  input  logic [DWORD_W-1:0]  wdata,
  input  logic [WORD_W-1:0]   tmp,
  input  logic                wr,
  output logic [ADDR_W-1:0]   addr,
  output logic [1:0]          size,
  output logic                beat_wr,
  output logic [WORD_W-1:0]   beat_wdata,
  output logic                code,
  output logic                last
);
  logic [BEAT_W:0]      n_beats;
  logic [ADDR_W-1:0]    step;
  logic [ADDR_W-1:0]    pair_step;
  logic [WORD_W-1:0]    hi_w, lo_w;

  always_comb begin
    step      = ADDR_W'(beat) << 2;
    pair_step = ADDR_W'(beat >> 1) << 2;
    hi_w      = wdata[DWORD_W-1:WORD_W];
    lo_w      = wdata[WORD_W-1:0];
    addr       = base;
    size       = 2'd2;
    beat_wr    = 1'b0;
    beat_wdata = '0;
    code       = 1'b0;
    n_beats    = (BEAT_W+1)'(1);
    case (route)
      RT_CODE, RT_PHYS: begin
        code    = (route == RT_CODE);
        beat_wr = wr;
        if (lg == 2'd3) begin
          n_beats    = (BEAT_W+1)'(2);
          addr       = base + step;
          beat_wdata = (beat == '0) ? hi_w : lo_w;
        end else begin
          size       = lg;
          beat_wdata = lo_w;
        end
      end
      RT_COPY: begin
        n_beats    = (BEAT_W+1)'(2 * COPY_WORDS);
        beat_wr    = beat[0];
        addr       = (beat[0] ? base : src) + pair_step;
        beat_wdata = beat[0] ? tmp : '0;
      end
      RT_FILL: begin
        n_beats    = (BEAT_W+1)'(COPY_WORDS);
        beat_wr    = 1'b1;
        addr       = base + step;
        beat_wdata = beat[0] ? lo_w : hi_w;
      end
      default: ;
    endcase
    last = ({1'b0, beat} == n_beats - 1'b1);
  end
endmodule

// File: rtl/altspace_router.sv
module altspace_router
  import altspace_pkg::*;
#(
  parameter int COPY_WORDS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ASI_W-1:0]    req_asi,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_size,
  input  logic                req_write,
  input  logic [DWORD_W-1:0]  req_wdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [1:0]          mem_size,
  output logic                mem_write,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                mem_code,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                resp_valid,
  output logic [DWORD_W-1:0]  resp_rdata,
  output logic                fault_valid,
  output logic [ADDR_W-1:0]   fault_addr,
  output logic                fault_write,
  output logic                fault_alt
);
  localparam int BEAT_W = $clog2(2 * COPY_WORDS);

  state_e               state_q;
  route_e               route_q, route_d;
  logic [1:0]           lg_q, lg_d;
  logic [ADDR_W-1:0]    base_q, base_d, src_q;
  logic [DWORD_W-1:0]   wdata_q, rdata_q;
  logic [WORD_W-1:0]    tmp_q;
  logic [BEAT_W-1:0]    beat_q;
  logic                 wr_q, flt_q;
  logic [ADDR_W-1:0]    faddr_q;

  // named events for the checker
  logic accept_fire, beat_fire, last_beat, no_beats;

  altspace_decode u_dec (
    .asi   (req_asi),
    .wr    (req_write),
    .route (route_d)
  );

  altspace_beatgen #(.COPY_WORDS(COPY_WORDS)) u_beat (
    .route      (route_q),
    .lg         (lg_q),
    .beat       (beat_q),
    .base       (base_q),
    .src        (src_q),
    .wdata      (wdata_q),
    .tmp        (tmp_q),
    .wr         (wr_q),
    .addr       (mem_addr),
    .size       (mem_size),
    .beat_wr    (mem_write),
    .beat_wdata (mem_wdata),
    .code       (mem_code),
    .last       (last_beat)
  );

  always_comb begin
    lg_d = size_lg(req_size);
    case (route_d)
      RT_COPY: base_d = align_to(req_addr, 2'd2);
      RT_FILL: base_d = {req_addr[ADDR_W-1:3], 3'b000};
      default: base_d = align_to(req_addr, lg_d);
    endcase
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign accept_fire = req_valid && req_ready;
  assign mem_valid   = (state_q == ST_BUSY);
  assign beat_fire   = mem_valid && mem_ready;
  assign no_beats    = (route_d == RT_NOP) || (route_d == RT_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      route_q <= RT_NOP;
      lg_q    <= 2'd2;
      base_q  <= '0;
      src_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      tmp_q   <= '0;
      beat_q  <= '0;
      wr_q    <= 1'b0;
      flt_q   <= 1'b0;
      faddr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_fire) begin
          route_q <= route_d;
          lg_q    <= lg_d;
          base_q  <= base_d;
          src_q   <= align_to(req_wdata[ADDR_W-1:0], 2'd2);
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          rdata_q <= '0;
          beat_q  <= '0;
          flt_q   <= (route_d == RT_FAULT);
          faddr_q <= req_addr;
          state_q <= no_beats ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: if (beat_fire) begin
          if (!mem_write) begin
            if (route_q == RT_COPY)
              tmp_q <= mem_rdata;
            else if (lg_q == 2'd3) begin
              if (beat_q == '0) rdata_q[DWORD_W-1:WORD_W] <= mem_rdata;
              else              rdata_q[WORD_W-1:0]       <= mem_rdata;
            end else
              rdata_q <= {{WORD_W{1'b0}}, zext_lg(mem_rdata, lg_q)};
          end
          if (last_beat) begin
            beat_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            beat_q  <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid  = (state_q == ST_DONE);
  assign resp_rdata  = rdata_q;
  assign fault_valid = resp_valid && flt_q;
  assign fault_addr  = faddr_q;
  assign fault_write = wr_q;
  assign fault_alt   = fault_valid;
endmodule

// File: rtl/altspace_router_chk.sv
module altspace_router_chk
  import altspace_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [1:0]         mem_size,
  input logic               mem_write,
  input logic [WORD_W-1:0]  mem_wdata,
  input logic               mem_code,
  input logic               resp_valid,
  input logic [DWORD_W-1:0] resp_rdata,
  input logic               fault_valid,
  input logic               fault_alt,
  input logic               accept_fire
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata));

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_one_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> resp_valid && fault_alt && resp_rdata == '0);

  p_fault_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(accept_fire));

  p_nop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !fault_valid && $past(accept_fire) |-> resp_rdata == '0);

  p_half_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_size == 2'd1 |-> !mem_addr[0]);

  p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_size == 2'd2 |-> mem_addr[1:0] == 2'b00);

  p_code_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_code |-> !mem_write);
endmodule

bind altspace_router altspace_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_size    (mem_size),
  .mem_write   (mem_write),
  .mem_wdata   (mem_wdata),
  .mem_code    (mem_code),
  .resp_valid  (resp_valid),
  .resp_rdata  (resp_rdata),
  .fault_valid (fault_valid),
  .fault_alt   (fault_alt),
  .accept_fire (accept_fire)
);

// File: tb/altspace_router_tb.sv
module altspace_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_asi = '0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd4;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        mem_valid, mem_write, mem_code;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic [31:0] mem_rdata = '0;
  logic        resp_valid, fault_valid, fault_write, fault_alt;
  logic [63:0] resp_rdata;
  logic [31:0] fault_addr;

  altspace_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_asi(req_asi), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_code(mem_code),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_write(fault_write), .fault_alt(fault_alt)
  );

  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0, tick = 0, hs_total = 0;
  logic stall = 1'b0;
  logic [31:0] mem [0:63];
  logic [31:0] lg_addr [0:31];
  logic [31:0] lg_wd [0:31];
  logic [31:0] lg_rd [0:31];
  logic        lg_wr [0:31];
  logic        lg_code [0:31];
  logic [1:0]  lg_size [0:31];

  function automatic logic [31:0] init_word(int i);
    return {8'(i), 8'(~i), 8'(i * 3), 8'(i ^ 8'h5A)};
  endfunction

  // memory model and beat log
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
    end else if (mem_valid && mem_ready) begin
      lg_addr[hs_total % 32] <= mem_addr;
      lg_wd[hs_total % 32]   <= mem_wdata;
      lg_rd[hs_total % 32]   <= mem_rdata;
      lg_wr[hs_total % 32]   <= mem_write;
      lg_code[hs_total % 32] <= mem_code;
      lg_size[hs_total % 32] <= mem_size;
      if (mem_write) mem[mem_addr[7:2]] <= mem_wdata;
      hs_total <= hs_total + 1;
    end
  end

  always @(negedge clk) begin
    tick <= tick + 1;
    mem_ready <= stall ? ((tick % 3) != 0) : 1'b1;
    mem_rdata <= mem[mem_addr[7:2]];
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // results of the last request
  logic        r_fault, r_fwr, r_falt, r_busy_ready;
  logic [31:0] r_faddr;
  logic [63:0] r_rdata;
  int          r_beats, r_start, r_lat;

  task automatic do_req(input logic [7:0] asi, input logic wr, input logic [31:0] a,
                        input logic [3:0] sz, input logic [63:0] wd);
    @(negedge clk);
    req_asi = asi; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    r_start = hs_total;
    @(negedge clk);
    req_valid = 1'b0;
    r_busy_ready = req_ready;
    r_lat = 0;
    while (!resp_valid && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    r_fault = fault_valid; r_fwr = fault_write; r_falt = fault_alt;
    r_faddr = fault_addr; r_rdata = resp_rdata;
    r_beats = hs_total - r_start;
  endtask

  function automatic int lidx(int k);
    return (r_start + k) % 32;
  endfunction

  // kinds: 0 none, 1 single beat, 2 fault, 3 copy, 4 fill
  function automatic int exp_kind(int asi, logic wr);
    if (asi == 32) return 1;
    if (asi == 2 || (asi >= 12 && asi <= 15)) return 0;
    if (!wr) return (asi == 9) ? 1 : 2;
    if ((asi >= 16 && asi <= 20) || asi == 49 || asi == 54 || asi == 55) return 0;
    if (asi == 23) return 3;
    if (asi == 31) return 4;
    return 2;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
    chk(!mem_valid && !resp_valid && !fault_valid, "R11 outputs idle",
        {61'd0, mem_valid, resp_valid, fault_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // routing sweep over every identifier, both directions
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 256; s++) begin
        int k, eb;
        k = exp_kind(s, w[0]);
        eb = (k == 1) ? 1 : (k == 3) ? 16 : (k == 4) ? 8 : 0;
        do_req(8'(s), w[0], 32'hC1, 4'd4, {32'h1234_5678, 32'h0000_0040});
        chk(r_fault == (k == 2), (k == 2) ? "R4 fault raised" :
            (w == 1 && s == 9) ? "R7 write fault" : "R5 R6 no fault",
            64'(r_fault), 64'(k == 2));
        chk(r_beats == eb, (k == 0) ? "R5 R6 no beats" : "R4 R8 R9 beat count",
            64'(r_beats), 64'(eb));
        chk(r_busy_ready == 1'b0, "R10 ready low while busy", 64'(r_busy_ready), 0);
        if (k == 0 || k == 2) begin
          chk(r_lat == 0 && r_rdata == 0, "R4 R5 zero and immediate",
              {32'(r_lat), r_rdata[31:0]}, 64'd0);
        end
        if (k == 2) begin
          chk(r_faddr == 32'hC1 && r_fwr == w[0] && r_falt,
              (w == 1 && s == 9) ? "R7 qualifiers" : "R4 qualifiers",
              {r_faddr, 30'd0, r_fwr, r_falt}, {32'hC1, 30'd0, w[0], 1'b1});
        end
      end
    end

    // R1: instruction-space reads of each size at 0x47
    begin
      logic [3:0]  szs [0:3];
      logic [31:0] ea  [0:3];
      logic [31:0] msk [0:3];
      logic [1:0]  ec  [0:3];
      szs[0] = 4'd1; ea[0] = 32'h47; msk[0] = 32'hFF;        ec[0] = 2'd0;
      szs[1] = 4'd2; ea[1] = 32'h46; msk[1] = 32'hFFFF;      ec[1] = 2'd1;
      szs[2] = 4'd4; ea[2] = 32'h44; msk[2] = 32'hFFFF_FFFF; ec[2] = 2'd2;
      szs[3] = 4'd3; ea[3] = 32'h44; msk[3] = 32'hFFFF_FFFF; ec[3] = 2'd2;
      for (int i = 0; i < 4; i++) begin
        do_req(8'h09, 1'b0, 32'h47, szs[i], 64'd0);
        chk(r_beats == 1 && lg_addr[lidx(0)] == ea[i] && lg_code[lidx(0)]
            && lg_size[lidx(0)] == ec[i], "R1 fetch beat",
            {lg_addr[lidx(0)], 30'(r_beats), lg_size[lidx(0)]},
            {ea[i], 30'd1, ec[i]});
        chk(r_rdata == {32'd0, mem[17] & msk[i]}, "R1 fetch data",
            r_rdata, {32'd0, mem[17] & msk[i]});
      end
    end

    // R2: doubleword reads, instruction then physical, second one stalled
    do_req(8'h09, 1'b0, 32'h47, 4'd8, 64'd0);
    chk(r_beats == 2 && lg_addr[lidx(0)] == 32'h44 && lg_addr[lidx(1)] == 32'h48,
        "R2 code pair addrs", {lg_addr[lidx(0)], lg_addr[lidx(1)]}, {32'h44, 32'h48});
    chk(r_rdata == {mem[17], mem[18]}, "R2 code pair data", r_rdata, {mem[17], mem[18]});
    stall = 1'b1;
    do_req(8'h20, 1'b0, 32'h4D, 4'd8, 64'd0);
    chk(r_beats == 2 && lg_addr[lidx(0)] == 32'h4C && lg_addr[lidx(1)] == 32'h50
        && !lg_code[lidx(0)], "R2 R3 phys pair addrs",
        {lg_addr[lidx(0)], lg_addr[lidx(1)]}, {32'h4C, 32'h50});
    chk(r_rdata == {mem[19], mem[20]}, "R2 R10 stalled pair data", r_rdata,
        {mem[19], mem[20]});
    stall = 1'b0;

    // R3: physical writes
    do_req(8'h20, 1'b1, 32'hE6, 4'd8, 64'hDEAD_BEEF_0BAD_F00D);
    chk(r_beats == 2 && lg_wr[lidx(0)] && lg_addr[lidx(0)] == 32'hE4
        && lg_wd[lidx(0)] == 32'hDEAD_BEEF, "R3 dword write hi",
        {lg_addr[lidx(0)], lg_wd[lidx(0)]}, {32'hE4, 32'hDEAD_BEEF});
    chk(lg_addr[lidx(1)] == 32'hE8 && lg_wd[lidx(1)] == 32'h0BAD_F00D,
        "R3 dword write lo", {lg_addr[lidx(1)], lg_wd[lidx(1)]},
        {32'hE8, 32'h0BAD_F00D});
    do_req(8'h20, 1'b1, 32'hE3, 4'd1, 64'h1111_2222_3333_44AB);
    chk(r_beats == 1 && lg_addr[lidx(0)] == 32'hE3 && lg_size[lidx(0)] == 2'd0
        && lg_wd[lidx(0)] == 32'h3333_44AB && !lg_code[lidx(0)], "R3 byte write",
        {lg_addr[lidx(0)], lg_wd[lidx(0)]}, {32'hE3, 32'h3333_44AB});

    // R8: block copy under stalls
    stall = 1'b1;
    do_req(8'h17, 1'b1, 32'hA2, 4'd4, 64'h0000_0000_0000_0013);
    stall = 1'b0;
    chk(r_beats == 16, "R8 copy beats", 64'(r_beats), 64'd16);
    for (int i = 0; i < 8; i++) begin
      int rb, wb;
      rb = lidx(2 * i); wb = lidx(2 * i + 1);
      chk(!lg_wr[rb] && lg_addr[rb] == 32'h10 + 32'(4 * i) && lg_wr[wb]
          && lg_addr[wb] == 32'hA0 + 32'(4 * i) && lg_wd[wb] == lg_rd[rb],
          "R8 copy pair", {lg_addr[rb], lg_addr[wb]},
          {32'h10 + 32'(4 * i), 32'hA0 + 32'(4 * i)});
    end

    // R9: block fill
    do_req(8'h1F, 1'b1, 32'h6D, 4'd8, 64'hCAFE_0001_BEEF_0002);
    chk(r_beats == 8, "R9 fill beats", 64'(r_beats), 64'd8);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ed;
      ed = (i % 2 == 0) ? 32'hCAFE_0001 : 32'hBEEF_0002;
      chk(lg_wr[lidx(i)] && lg_addr[lidx(i)] == 32'h68 + 32'(4 * i)
          && lg_wd[lidx(i)] == ed, "R9 fill word",
          {lg_addr[lidx(i)], lg_wd[lidx(i)]}, {32'h68 + 32'(4 * i), ed});
    end

    report();
    $finish;
  end
endmodule